// File: doc/BRIEF.md
# Binary-Weighted Bit-Plane Colour Sequencer

This block drives a binary on/off spatial light modulator from a frame that has already been split into bit planes. It divides each frame into three equal colour slots: red, then green, then blue. Each slot is split into one interval per bit plane, and the intervals grow in binary proportion, so the time a mirror spends lit tracks the pixel's binary value. The outputs tell the plane memory which colour and bit index to present. They also give a one-cycle strobe to load the next plane and an illumination enable for the light source.

The slot length is given in clock ticks. The unit time is the slot length divided by 2^depth − 1, rounded down. Any ticks left over form a dark tail at the end of each slot. A frame-sync pulse latches the configuration and restarts the sequence at red, bit 0. Between syncs the three-slot frame repeats on its own. The `slot_len` port must be at least 11 bits wide (`SLOT_W` ≥ 11).

Top module: `bitplane_pwm_seq`

## Requirements
- R1: While reset is asserted, and afterwards until the first frame sync, all four outputs are 0.
- R2: When `frame_sync` is sampled high at rising edge E, the outputs after edge E+1 form a preload cycle: `plane_load`=1, `illum_en`=0, `color`=0, `bit_index`=0. The first tick of red bit 0 follows after edge E+2.
- R3: Colour codes are 0 red, 1 green, 2 blue. Each slot lasts L ticks, and the slots run in that order. After blue the sequence continues at red without a new sync.
- R4: The depth code selects the number of planes D: code 0 gives 8, code 1 gives 9, and codes 2 and 3 give 10. Within a slot, `bit_index` counts up from 0 to D−1.
- R5: The effective slot length is L = max(`slot_len`, 2^D−1). The unit is U = floor(L/(2^D−1)), and bit k is lit for exactly U·2^k ticks.
- R6: The last L − U·(2^D−1) ticks of each slot are dark. In the dark tail `illum_en`=0 and `bit_index` holds D−1. Outside the tail, `illum_en`=1.
- R7: `plane_load` is high exactly in the last tick before a bit interval begins. This includes bit 0 of the next slot and of the next frame. It is never high before a dark tail.
- R8: A sync that arrives in the middle of a frame abandons that frame and starts the preload of R2 at once.
- R9: `slot_len` and `depth_code` are sampled only on a sync edge. Changing them between syncs has no effect on the outputs.
- R10: While `frame_sync` stays high on consecutive edges, the preload cycle repeats. The sequence starts only after the sync drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame restart and configuration latch |
| slot_len | input | SLOT_W | Colour slot length in ticks |
| depth_code | input | 2 | Bit depth select (8/9/10) |
| color | output | 2 | Current colour slot |
| bit_index | output | 4 | Current bit plane |
| plane_load | output | 1 | Load the next plane, one tick ahead |
| illum_en | output | 1 | Light source enable |

## Verification
Every internal state change shows at the outputs one rising edge later. A sync sampled at edge E therefore gives the preload after E+1 and the first lit tick after E+2. Each later tick's colour, bit, strobe and enable also appear one edge after the state that produced them. The bench's behavioural model updates its frame position on the same edge and registers its expected outputs with the same one-edge lag. The bench compares every output at each falling edge, and it also counts the strobes and lit ticks over exact frame windows.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int unsigned DEPTH_W = 4;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_PRE  = 2'd1,
    MODE_RUN  = 2'd2
  } mode_t;

  function automatic logic [DEPTH_W-1:0] depth_of(input logic [1:0] code);
    case (code)
      2'd0:    depth_of = DEPTH_W'(8);
      2'd1:    depth_of = DEPTH_W'(9);
      default: depth_of = DEPTH_W'(10);
    endcase
  endfunction
endpackage

// File: rtl/bps_cfg.sv
module bps_cfg
  import bps_pkg::*;
#(
  parameter int unsigned SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic [SLOT_W-1:0] slot_len_i,
  input  logic [1:0]        depth_code_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic [SLOT_W-1:0] len_o,
  output logic [SLOT_W-1:0] unit_o,
  output logic [SLOT_W-1:0] dark_o
);
  logic [DEPTH_W-1:0] d_n;
  logic [SLOT_W-1:0]  denom, eff, unit_n, prod;

  always_comb begin
    d_n    = depth_of(depth_code_i);
    denom  = (SLOT_W'(1) << d_n) - SLOT_W'(1);
    eff    = (slot_len_i < denom) ? denom : slot_len_i;
    unit_n = eff / denom;
    prod   = unit_n * denom;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_o <= '0;
      len_o   <= '0;
      unit_o  <= '0;
      dark_o  <= '0;
    end else if (sync_i) begin
      depth_o <= d_n;
      len_o   <= eff;
      unit_o  <= unit_n;
      dark_o  <= prod;
    end
  end

  // R9: configuration only moves on a sync edge
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !sync_i |=> ($stable(unit_o) && $stable(len_o) && $stable(depth_o)));
  // R5: a latched unit is never zero
  p_unit_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (unit_o != '0 && dark_o <= len_o));
endmodule

// File: rtl/bps_timer.sv
module bps_timer
  import bps_pkg::*;
#(
  parameter int unsigned SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_i,
  input  logic [SLOT_W-1:0] len_i,
  output mode_t             mode_o,
  output logic [1:0]        slot_o,
  output logic [SLOT_W-1:0] off_o,
  output logic              wrap_o
);
  assign wrap_o = (mode_o == MODE_RUN) && (off_o == len_i - SLOT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= MODE_IDLE;
      slot_o <= 2'd0;
      off_o  <= '0;
    end else if (sync_i) begin
      mode_o <= MODE_PRE;
    end else begin
      case (mode_o)
        MODE_PRE: begin
          mode_o <= MODE_RUN;
          slot_o <= 2'd0;
          off_o  <= '0;
        end
        MODE_RUN: begin
          if (wrap_o) begin
            off_o  <= '0;
            slot_o <= (slot_o == 2'd2) ? 2'd0 : slot_o + 2'd1;
          end else begin
            off_o <= off_o + SLOT_W'(1);
          end
        end
        default: mode_o <= MODE_IDLE;
      endcase
    end
  end

  // R3: only three colour slots exist
  p_slot_range_r3: assert property (@(posedge clk) disable iff (rst)
    slot_o != 2'd3);
  // R3: the offset stays inside the slot
  p_off_in_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_RUN) |-> (off_o < len_i));
  // R3: a slot end restarts the offset
  p_wrap_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (wrap_o && !sync_i) |=> (off_o == '0));
endmodule

// File: rtl/bps_plane.sv
module bps_plane
  import bps_pkg::*;
#(
  parameter int unsigned SLOT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  mode_t              mode_i,
  input  logic               wrap_i,
  input  logic [SLOT_W-1:0]  off_i,
  input  logic [SLOT_W-1:0]  unit_i,
  input  logic [SLOT_W-1:0]  dark_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [DEPTH_W-1:0] bit_o,
  output logic               step_o
);
  logic [SLOT_W-1:0] ivl_end;
  logic [SLOT_W-1:0] next_len;

  assign next_len = unit_i << (bit_o + DEPTH_W'(1));
  assign step_o   = (mode_i == MODE_RUN) && !wrap_i &&
                    (off_i == ivl_end - SLOT_W'(1)) &&
                    (bit_o < depth_i - DEPTH_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_o   <= '0;
      ivl_end <= '0;
    end else if (mode_i == MODE_PRE || wrap_i) begin
      bit_o   <= '0;
      ivl_end <= unit_i;
    end else if (step_o) begin
      bit_o   <= bit_o + DEPTH_W'(1);
      ivl_end <= ivl_end + next_len;
    end
  end

  // R4: bit index never reaches the depth
  p_bit_below_depth_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RUN) |-> (bit_o < depth_i));
  // R5: interval boundaries never pass the start of the dark tail
  p_ivl_in_slot_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_RUN) |-> (ivl_end <= dark_i));
endmodule

// File: rtl/bitplane_pwm_seq.sv
module bitplane_pwm_seq
  import bps_pkg::*;
#(
  parameter int unsigned SLOT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_sync,
  input  logic [SLOT_W-1:0]  slot_len,
  input  logic [1:0]         depth_code,
  output logic [1:0]         color,
  output logic [DEPTH_W-1:0] bit_index,
  output logic               plane_load,
  output logic               illum_en
);
  logic [DEPTH_W-1:0] depth;
  logic [SLOT_W-1:0]  len, unit, dark, off;
  mode_t              mode;
  logic [1:0]         slot;
  logic               wrap, step;
  logic [DEPTH_W-1:0] bit_cur;

  bps_cfg #(.SLOT_W(SLOT_W)) u_cfg (
    .clk(clk), .rst(rst), .sync_i(frame_sync), .slot_len_i(slot_len),
    .depth_code_i(depth_code), .depth_o(depth), .len_o(len),
    .unit_o(unit), .dark_o(dark)
  );

  bps_timer #(.SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst(rst), .sync_i(frame_sync), .len_i(len),
    .mode_o(mode), .slot_o(slot), .off_o(off), .wrap_o(wrap)
  );

  bps_plane #(.SLOT_W(SLOT_W)) u_plane (
    .clk(clk), .rst(rst), .mode_i(mode), .wrap_i(wrap), .off_i(off),
    .unit_i(unit), .dark_i(dark), .depth_i(depth),
    .bit_o(bit_cur), .step_o(step)
  );

  logic run, pre;
  assign run = (mode == MODE_RUN);
  assign pre = (mode == MODE_PRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      color      <= 2'd0;
      bit_index  <= '0;
      plane_load <= 1'b0;
      illum_en   <= 1'b0;
    end else begin
      color      <= run ? slot : 2'd0;
      bit_index  <= run ? bit_cur : '0;
      plane_load <= pre || wrap || step;
      illum_en   <= run && (off < dark);
    end
  end

  // R1: nothing happens before a sync
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_IDLE) |=> (!plane_load && !illum_en && color == 2'd0));
  // R2: preload cycle follows the sync
  p_preload_r2: assert property (@(posedge clk) disable iff (rst)
    pre |=> (plane_load && !illum_en && color == 2'd0 && bit_index == '0));
  // R6: dark tail is unlit and holds the top bit
  p_dark_tail_r6: assert property (@(posedge clk) disable iff (rst)
    (run && off >= dark) |=> (!illum_en && bit_index == $past(depth) - DEPTH_W'(1)));
  // R7: no strobe in the middle of a dark tail
  p_no_dark_load_r7: assert property (@(posedge clk) disable iff (rst)
    (run && off >= dark && !wrap) |=> !plane_load);
endmodule

// File: tb/sim_bitplane_pwm_seq.sv
module sim_bitplane_pwm_seq;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fs  = 1'b0;
  logic [SW-1:0] sl = SW'(300);
  logic [1:0] dc = 2'd0;
  logic [1:0] color;
  logic [3:0] bit_index;
  logic plane_load, illum_en;

  always #10 clk = ~clk;

  bitplane_pwm_seq #(.SLOT_W(SW)) u0 (
    .clk(clk), .rst(rst), .frame_sync(fs), .slot_len(sl), .depth_code(dc),
    .color(color), .bit_index(bit_index), .plane_load(plane_load), .illum_en(illum_en)
  );

  int m_mode = 0, m_p = 0, m_L = 1, m_unit = 1, m_D = 8;
  int e_color = 0, e_bit = 0, e_load = 0, e_illum = 0;
  int n_tests = 0, n_fail = 0, cyc = 0;
  string tag = "R1";
  bit cmp_on = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      if (n_fail <= 20)
        $display("FAIL %s (phase %s): actual %0d expected %0d", req, tag, got, exp);
    end
  endtask

  // behavioural reference: frame position counter, outputs lag one edge
  always @(posedge clk) begin : model
    int s, o, k, dk, nc, nb, nl, ni, den;
    nc = 0; nb = 0; nl = 0; ni = 0;
    if (!rst && m_mode == 1) nl = 1;
    else if (!rst && m_mode == 2) begin
      s = m_p / m_L; o = m_p % m_L;
      dk = m_unit * ((1 << m_D) - 1);
      nc = s;
      if (o >= dk) begin k = m_D - 1; ni = 0; end
      else begin
        k = 0;
        while (o >= m_unit * ((1 << (k + 1)) - 1)) k++;
        ni = 1;
      end
      nb = k;
      nl = ((o == m_L - 1) || (o < dk && k < m_D - 1 &&
            o + 1 == m_unit * ((1 << (k + 1)) - 1))) ? 1 : 0;
    end
    e_color = nc; e_bit = nb; e_load = nl; e_illum = ni;
    if (rst) m_mode = 0;
    else if (fs) begin
      m_D = (dc == 2'd0) ? 8 : (dc == 2'd1) ? 9 : 10;
      den = (1 << m_D) - 1;
      m_L = (int'(sl) < den) ? den : int'(sl);
      m_unit = m_L / den;
      m_mode = 1;
    end else if (m_mode == 1) begin m_mode = 2; m_p = 0; end
    else if (m_mode == 2) m_p = (m_p + 1) % (3 * m_L);
    cyc++;
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(color == e_color, "R3 colour", color, e_color);
      chk(bit_index == e_bit, "R4 bit index", bit_index, e_bit);
      chk(plane_load == e_load, "R7 load strobe", plane_load, e_load);
      chk(illum_en == e_illum, "R6 illumination", illum_en, e_illum);
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000 && !done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_preload(input string req);
    chk(plane_load && !illum_en && color == 2'd0 && bit_index == 4'd0, req,
        int'({plane_load, illum_en}), 2);
  endtask

  task automatic do_sync(input string t);
    tag = t;
    fs = 1'b1; @(negedge clk); fs = 1'b0;
    @(negedge clk);
    check_preload({t, " preload"});
  endtask

  task automatic count_window(input int n, output int loads, output int lit);
    loads = 0; lit = 0;
    repeat (n) begin
      if (plane_load) loads++;
      if (illum_en) lit++;
      @(negedge clk);
    end
  endtask

  initial begin
    int ld, lt;
    tick(3);
    cmp_on = 1;
    chk(color == 0 && bit_index == 0 && !plane_load && !illum_en, "R1 reset outputs",
        int'({plane_load, illum_en}), 0);
    rst = 1'b0;
    tick(20);
    chk(!plane_load && !illum_en, "R1 idle before sync", int'({plane_load, illum_en}), 0);

    // 8 planes, unit 1, dark 45
    sl = SW'(300); dc = 2'd0;
    do_sync("R2");
    count_window(1 + 900, ld, lt);
    chk(ld == 25, "R7 strobes per frame", ld, 25);
    chk(lt == 765, "R5 lit ticks per frame", lt, 765);
    tick(900);

    // unit 2; config change without sync must be ignored
    sl = SW'(600); dc = 2'd0;
    do_sync("R2");
    tick(700);
    tag = "R9"; sl = SW'(999); dc = 2'd2;
    tick(1200);

    // 9 planes, then an early sync
    sl = SW'(1100); dc = 2'd1;
    do_sync("R4");
    tick(1500);
    do_sync("R8");
    tick(3400);

    // 10 planes, no dark tail
    sl = SW'(1023); dc = 2'd2;
    do_sync("R4");
    tick(3100);
    // code 3 also 10 planes, unit 2, dark 54
    sl = SW'(2100); dc = 2'd3;
    do_sync("R4");
    count_window(1 + 6300, ld, lt);
    chk(ld == 31, "R7 strobes per 10-plane frame", ld, 31);
    chk(lt == 6138, "R6 lit ticks with dark tail", lt, 6138);

    // short slot clamped to 255
    sl = SW'(100); dc = 2'd0;
    do_sync("R5");
    count_window(1 + 765, ld, lt);
    chk(lt == 765, "R5 clamped slot fully lit", lt, 765);
    chk(ld == 25, "R5 clamped slot strobes", ld, 25);

    // held sync
    tag = "R10"; sl = SW'(300);
    fs = 1'b1; tick(3); fs = 1'b0;
    check_preload("R10 held sync preload");
    tick(1);
    check_preload("R10 preload repeats");
    tick(2000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule